// File: doc/BRIEF.md
# Framed Serial Transmitter with End-of-Frame Marker

This block serializes one byte at a time onto an asynchronous line. It sends either a ten-bit frame or an eleven-bit frame. The ten-bit frame is a low start bit, eight data bits least significant first, and a high stop bit. The eleven-bit frame adds a programmable extra bit between the last data bit and the stop bit. An oversampling tick at sixteen times the bit rate drives a free-running phase counter. Every bit boundary of the line falls on a wrap of that counter, never on the cycle of the load.

A load strobe passes the byte, the frame-length select and the extra-bit value into a shift register. A marker bit sits just above the last bit to be sent. The register shifts right once per bit time and fills with zeros. The controller ends the frame when the marker has reached the position just above the output bit and everything above the marker is zero. No bit counter is needed. The completion flag then rises and stays up until the next accepted load.

Top module: `utx_marker_tx`

## Requirements
- R1: While reset is asserted and on leaving it, `txd` is 1 and `tx_done` is 0.
- R2: Whenever no frame is on the line (idle, or a load waiting for its first counter wrap), `txd` is 1. After a frame the line stays high, and this high level is the stop bit.
- R3: After an accepted load, `txd` stays high until the first wrap of the divide-by-`OSR` counter that follows the load cycle. In the cycle after that wrap, `txd` goes to 0 and holds the start bit for one bit time, which is `OSR` ticks.
- R4: After the start bit come the data bits, bit 0 first, each for one bit time and each beginning in the cycle after a counter wrap.
- R5: In nine-bit mode (`nine_bit`=1 at the load), the value of `tb8` at the load is sent for one bit time directly after data bit 7, and the stop bit follows it.
- R6: `tx_done` rises in the cycle after the 10th counter wrap that follows the load in eight-bit mode, and after the 11th in nine-bit mode. It then stays 1 until the next accepted load.
- R7: A load strobe that arrives while a frame is waiting or on the line is ignored. The frame in progress and its timing are unchanged.
- R8: A counter wrap in the same cycle as an accepted load does not count as the first wrap. The start bit waits for the following wrap.
- R9: An accepted load clears `tx_done` in the next cycle.
- R10: `nine_bit` and `tb8` are captured at the load. Changing them afterwards does not alter the length or the content of the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16x | input | 1 | One-cycle oversampling tick, `OSR` per bit time |
| wr_stb | input | 1 | Load strobe for a new byte |
| wr_data | input | DATA_W | Byte to send |
| nine_bit | input | 1 | 1 selects the eleven-bit frame |
| tb8 | input | 1 | Value of the extra bit in nine-bit mode |
| txd | output | 1 | Serial line, idle high |
| tx_done | output | 1 | Frame completed, held until the next accepted load |

## Verification
The bench sends bytes whose low bits are `0x02`, `0x03`, `0x00` and `0xFF`. In nine-bit mode, a design that tested for the end pattern before the first shift would see the pattern and cut those frames after the start bit. Loads are placed exactly on a counter wrap. A design that counted that wrap would start the frame one bit time early and raise the flag one wrap too soon. Further loads are issued while a frame is waiting and while it is on the line, to catch a design that lets a late byte overwrite the shift register. The mode inputs are changed after each load, to expose a frame length that follows the live select instead of the captured one.

// File: rtl/utx_pkg.sv
package utx_pkg;

   typedef enum logic [1:0] {
      UTX_IDLE  = 2'd0,
      UTX_WAIT  = 2'd1,
      UTX_START = 2'd2,
      UTX_DATA  = 2'd3
   } utx_state_e;

endpackage

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
   parameter int OSR = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic roll
);
   generate
      if (OSR == 1) begin : g_direct
         assign roll = tick;
      end else begin : g_count
         localparam int CW = $clog2(OSR);
         localparam logic [CW-1:0] LAST = CW'(OSR - 1);
         logic [CW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    phase_q <= '0;
            else if (tick) phase_q <= phase_q + 1'b1;
         end

         assign roll = tick && (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         fill,
   output logic [W-1:0] sh_q,
   output logic         out_bit,
   output logic         tail_match
);
   logic [W-3:0] upper_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= '1;
      else if (load)  sh_q <= load_val;
      else if (shift) sh_q <= {fill, sh_q[W-1:1]};
   end

   genvar gi;
   generate
      for (gi = 2; gi < W; gi++) begin : g_upper
         assign upper_bits[gi-2] = sh_q[gi];
      end
   endgenerate

   assign out_bit    = sh_q[0];
   assign tail_match = sh_q[1] && (upper_bits == '0);
endmodule

// File: rtl/utx_ctrl.sv
module utx_ctrl
   import utx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       roll,
   input  logic       wr_stb,
   input  logic       nine_bit,
   input  logic       tail_match,
   input  logic       out_bit,
   output logic       load,
   output logic       shift,
   output logic       fill,
   output utx_state_e st,
   output logic       txd,
   output logic       tx_done
);
   logic nine_q;
   logic shifted_q;
   logic accept;
   logic last_shift;

   assign accept     = wr_stb && (st == UTX_IDLE);
   assign load       = accept;
   assign shift      = roll && (st == UTX_DATA);
   assign fill       = !shifted_q && nine_q;
   assign last_shift = shifted_q && tail_match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= UTX_IDLE;
         tx_done   <= 1'b0;
         nine_q    <= 1'b0;
         shifted_q <= 1'b0;
      end else if (accept) begin
         st        <= UTX_WAIT;
         tx_done   <= 1'b0;
         nine_q    <= nine_bit;
         shifted_q <= 1'b0;
      end else if (roll) begin
         case (st)
            UTX_WAIT:  st <= UTX_START;
            UTX_START: st <= UTX_DATA;
            UTX_DATA: begin
               shifted_q <= 1'b1;
               if (last_shift) begin
                  st      <= UTX_IDLE;
                  tx_done <= 1'b1;
               end
            end
            default:   st <= st;
         endcase
      end
   end

   always_comb begin
      case (st)
         UTX_START: txd = 1'b0;
         UTX_DATA:  txd = out_bit;
         default:   txd = 1'b1;
      endcase
   end
endmodule

// File: rtl/utx_marker_tx.sv
module utx_marker_tx
   import utx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16x,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              nine_bit,
   input  logic              tb8,
   output logic              txd,
   output logic              tx_done
);
   localparam int SR_W = DATA_W + 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("utx_marker_tx: DATA_W must be at least 2");
      end
      if (OSR < 1 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("utx_marker_tx: OSR must be a power of two");
      end
   endgenerate

   logic            roll;
   logic            load;
   logic            shift;
   logic            fill;
   logic            out_bit;
   logic            tail_match;
   logic [SR_W-1:0] sh_q;
   logic [SR_W-1:0] load_val;
   utx_state_e      st;

   assign load_val = {(nine_bit ? tb8 : 1'b1), wr_data};

   utx_bit_timer #(.OSR(OSR)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick16x),
      .roll  (roll)
   );

   utx_shifter #(.W(SR_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_val   (load_val),
      .shift      (shift),
      .fill       (fill),
      .sh_q       (sh_q),
      .out_bit    (out_bit),
      .tail_match (tail_match)
   );

   utx_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .roll       (roll),
      .wr_stb     (wr_stb),
      .nine_bit   (nine_bit),
      .tail_match (tail_match),
      .out_bit    (out_bit),
      .load       (load),
      .shift      (shift),
      .fill       (fill),
      .st         (st),
      .txd        (txd),
      .tx_done    (tx_done)
   );
endmodule

// File: rtl/utx_marker_tx_chk.sv
module utx_marker_tx_chk
   import utx_pkg::*;
#(
   parameter int SR_W = 9
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_stb,
   input logic            roll,
   input utx_state_e      st,
   input logic [SR_W-1:0] sh_q,
   input logic            txd,
   input logic            tx_done
);
   // R1
   a_r1_reset_vals: assert property (@(posedge clk)
      !rst_n |=> (txd && !tx_done));

   // R2
   a_r2_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (st == UTX_IDLE || st == UTX_WAIT) |-> txd);

   // R3
   a_r3_start_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
      (st == UTX_WAIT && roll) |=> (!txd && st == UTX_START));

   // R6
   a_r6_done_after_roll: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> $past(roll));

   a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !wr_stb) |=> tx_done);

   // R7
   a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && st != UTX_IDLE && !roll) |=> ($stable(sh_q) && $stable(st)));

   // R9
   a_r9_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && st == UTX_IDLE) |=> (!tx_done && st == UTX_WAIT));
endmodule

bind utx_marker_tx utx_marker_tx_chk #(.SR_W(SR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_stb  (wr_stb),
   .roll    (roll),
   .st      (st),
   .sh_q    (sh_q),
   .txd     (txd),
   .tx_done (tx_done)
);

// File: tb/tb_utx_marker_tx.sv
module tb_utx_marker_tx;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 8;
   localparam int OSR = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic wr = 1'b0;
   logic nine = 1'b0;
   logic t8 = 1'b0;
   logic [DW-1:0] wdat = '0;
   logic txd;
   logic done;

   utx_marker_tx #(.DATA_W(DW), .OSR(OSR)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick16x  (tick),
      .wr_stb   (wr),
      .wr_data  (wdat),
      .nine_bit (nine),
      .tb8      (t8),
      .txd      (txd),
      .tx_done  (done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // tick every second cycle
   int cyc = 0;
   always @(negedge clk) begin
      cyc  <= cyc + 1;
      tick <= (cyc % 2 == 1);
   end

   // behavioural reference model
   int m_cnt = 0;
   int m_st = 0;        // 0 idle, 1 waiting, 2 on line
   int m_idx = 0;
   int m_n = 9;
   int m_rolls = 0;
   bit m_done = 0;
   bit m_nine = 0;
   bit m_roll;
   bit m_bits[0:9];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_st = 0; m_idx = 0; m_done = 0; m_rolls = 0;
      end else begin
         m_roll = tick && (m_cnt == OSR - 1);
         if (tick) m_cnt = (m_cnt + 1) % OSR;
         if (wr && m_st == 0) begin
            m_st = 1; m_done = 0; m_rolls = 0; m_nine = nine;
            m_bits[0] = 1'b0;
            for (int i = 0; i < DW; i++) m_bits[i+1] = wdat[i];
            m_bits[9] = t8;
            m_n = nine ? 10 : 9;
         end else if (m_roll) begin
            m_rolls++;
            if (m_st == 1) begin
               m_st = 2; m_idx = 0;
            end else if (m_st == 2) begin
               m_idx++;
               if (m_idx == m_n) begin
                  m_st = 0; m_done = 1;
               end
            end
         end
      end
   end

   // per-cycle comparison and frame capture
   bit cap[0:9];
   bit prev_done = 0;
   bit aligned_flag = 0;

   always @(negedge clk) begin
      #1;
      if (rst_n && !finished) begin
         bit exp_txd;
         string tag;
         exp_txd = (m_st == 2) ? m_bits[m_idx] : 1'b1;
         if (m_st != 2)       tag = "R2";
         else if (m_idx == 0) tag = "R3";
         else if (m_idx <= 8) tag = "R4";
         else                 tag = "R5";
         chk(txd === exp_txd, tag, "txd vs model", int'(txd), int'(exp_txd));
         chk(done === m_done, "R6", "tx_done vs model", int'(done), int'(m_done));
         if (m_st == 2 && tick && m_cnt == OSR - 1) cap[m_idx] = txd;
         if (done && !prev_done)
            chk(m_rolls == (m_nine ? 11 : 10), aligned_flag ? "R8" : "R6",
                "wraps from load to done", m_rolls, m_nine ? 11 : 10);
         prev_done = done;
      end
   end

   function automatic int rx_byte();
      int v = 0;
      for (int i = 0; i < DW; i++) if (cap[i+1]) v |= (1 << i);
      return v;
   endfunction

   task automatic load(input logic [DW-1:0] d, input bit nb, input bit b8);
      @(negedge clk);
      wr = 1'b1; wdat = d; nine = nb; t8 = b8;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic load_on_wrap(input logic [DW-1:0] d, input bit nb, input bit b8);
      @(negedge clk); #1;
      while (!(tick && m_cnt == OSR - 1)) begin
         @(negedge clk); #1;
      end
      wr = 1'b1; wdat = d; nine = nb; t8 = b8;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic wait_done();
      int k = 0;
      while (!done && k < 5000) begin
         @(negedge clk); k++;
      end
      #2;
      chk(done === 1'b1, "R6", "frame completes", int'(done), 1);
   endtask

   task automatic frame(input logic [DW-1:0] d, input bit nb, input bit b8,
                        input string req);
      load(d, nb, b8);
      wait_done();
      chk(rx_byte() == int'(d), req, "received byte", rx_byte(), int'(d));
      if (nb) chk(cap[9] == b8, "R5", "ninth bit", int'(cap[9]), int'(b8));
      chk(cap[0] == 1'b0, "R3", "start bit", int'(cap[0]), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      #2;
      chk(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
      chk(done === 1'b0, "R1", "tx_done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
      chk(done === 1'b0, "R1", "tx_done after reset", int'(done), 0);
      repeat (20) @(negedge clk);

      // R4 eight-bit frames, patterns that resemble the end marker
      frame(8'hA5, 1'b0, 1'b0, "R4");
      frame(8'h03, 1'b0, 1'b0, "R4");
      frame(8'h00, 1'b0, 1'b0, "R4");
      frame(8'hFF, 1'b0, 1'b0, "R4");
      // R5 nine-bit frames
      frame(8'h3C, 1'b1, 1'b1, "R5");
      frame(8'h02, 1'b1, 1'b0, "R5");
      frame(8'h03, 1'b1, 1'b0, "R5");
      frame(8'h00, 1'b1, 1'b1, "R5");

      // R2 line stays high after the frame (stop bit), R6 flag holds
      repeat (40) @(negedge clk);
      #2;
      chk(txd === 1'b1, "R2", "idle line high", int'(txd), 1);
      chk(done === 1'b1, "R6", "done held", int'(done), 1);

      // R9 accepted load clears flag
      load(8'h11, 1'b0, 1'b0);
      #2;
      chk(done === 1'b0, "R9", "done cleared by load", int'(done), 0);
      // R7 loads while waiting and while on the line
      load(8'h77, 1'b1, 1'b1);
      repeat (100) @(negedge clk);
      load(8'h55, 1'b0, 1'b0);
      wait_done();
      chk(rx_byte() == 8'h11, "R7", "busy load ignored", rx_byte(), 8'h11);

      // R10 mode inputs changed after load
      load(8'h5A, 1'b1, 1'b0);
      nine = 1'b0; t8 = 1'b1;
      wait_done();
      chk(rx_byte() == 8'h5A, "R10", "byte with late mode change", rx_byte(), 8'h5A);
      chk(cap[9] == 1'b0, "R10", "captured ninth bit", int'(cap[9]), 0);
      load(8'hC3, 1'b0, 1'b0);
      nine = 1'b1; t8 = 1'b0;
      wait_done();
      chk(rx_byte() == 8'hC3, "R10", "eight-bit frame kept", rx_byte(), 8'hC3);
      repeat (40) @(negedge clk);

      // R8 load coinciding with a counter wrap
      aligned_flag = 1;
      load_on_wrap(8'h81, 1'b0, 1'b0);
      repeat (OSR * 2 - 4) @(negedge clk);
      #2;
      chk(txd === 1'b1, "R8", "no start on coinciding wrap", int'(txd), 1);
      wait_done();
      chk(rx_byte() == 8'h81, "R8", "aligned byte", rx_byte(), 8'h81);
      load_on_wrap(8'h96, 1'b1, 1'b1);
      wait_done();
      chk(cap[9] == 1'b1, "R8", "aligned ninth bit", int'(cap[9]), 1);
      aligned_flag = 0;
      repeat (40) @(negedge clk);

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule